// File: doc/BRIEF.md
# Lockable Temperature Sensor Register Bank

This block holds the eight 16-bit registers of a temperature sensor behind a simple synchronous register port. A serial-bus front end turns bus transactions into single-cycle writes and combinational reads. The block applies every write rule of the sensor itself. Identification and capability words are constants. The temperature word is passed through from the converter. The three temperature limits keep only their meaningful bits. The configuration word is split into decoded control fields that the event logic and the converter consume.

The configuration word has two sticky lock bits, one for the alarm limits and one for the critical limit. Once either is set, only a reset clears it. While a lock is set, the event mode, output polarity, output enable and hysteresis fields are frozen, and shutdown can be released but not requested. The alarm lock also prevents the critical-only mode from being turned on, and it freezes the upper and lower alarm limits. The critical lock freezes the critical limit. A lock takes effect from the write after the one that sets it. Writing a one to the event-clear position sends a single-cycle pulse to the event logic, and that position always reads back as zero.

Top module: `tsreg_top`

## Requirements
- R1: After reset, reads return 0x007F at address 0, 0x0000 at addresses 1 to 4, 0x1B09 at address 6 and 0x0813 at address 7. Address 5 always returns the `tempIn` input.
- R2: Writes to addresses 0, 5, 6 and 7 change nothing readable.
- R3: A limit write (address 2 upper, 3 lower, 4 critical) keeps bits 12:2 of the data. Bits 15:13 and 1:0 read as 0.
- R4: The configuration word (address 1) reads bits 15:11 and bit 5 as 0. Bit 4 reads the `eventStatus` input.
- R5: A configuration write with bit 5 set raises `clearPulse` for exactly the one cycle that follows the write edge.
- R6: Lock bits 6 (alarm) and 7 (critical) are set by writing 1 and stay set until reset, whatever is written later.
- R7: While either lock is set, bit 0 (interrupt mode), bit 1 (active-high polarity), bit 3 (output enable) and bits 10:9 (hysteresis) keep their value.
- R8: While either lock is set, bit 8 (shutdown) can be cleared by writing 0 but cannot be set.
- R9: While the alarm lock is set, bit 2 (critical-only) can be cleared but not set. The critical lock alone does not restrict it.
- R10: The alarm lock blocks writes to the upper and lower limits. The critical lock blocks writes to the critical limit.
- R11: Fields written in the same write that sets a lock are stored as if unlocked.
- R12: The decoded outputs (mode, polarity, critical-only, enable, shutdown, hysteresis, locks, limits) always equal the corresponding readable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| regAddr | input | 3 | Register address for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `regAddr` |
| tempIn | input | 16 | Temperature word from the converter |
| eventStatus | input | 1 | Current event output state from the event logic |
| cfgIntMode | output | 1 | 1 = interrupt mode, 0 = comparator mode |
| cfgPolHigh | output | 1 | 1 = event output active high |
| cfgCritOnly | output | 1 | Events from the critical limit only |
| cfgOutEnable | output | 1 | Event output enabled |
| cfgShutdown | output | 1 | Converter shut down |
| cfgHyst | output | 2 | Hysteresis select |
| alarmLocked | output | 1 | Alarm lock state |
| critLocked | output | 1 | Critical lock state |
| highLimit | output | 16 | Upper alarm limit |
| lowLimit | output | 16 | Lower alarm limit |
| critLimit | output | 16 | Critical limit |
| clearPulse | output | 1 | One-cycle event-clear request |

## Verification
The bench goes after the asymmetric lock rules. Under a lock, shutdown and critical-only must be clearable but not settable. A design that froze these fields completely would fail the clear check, and one that ignored the lock would fail the set check. The same-write case targets a design that applied a new lock to its own write and lost the fields written alongside it. The tests also separate the two locks: each must freeze only its own limits, and the critical lock must leave critical-only free. Sweeps over limit data and over unlocked configuration words catch wrong masking, reserved bits that leak through, or a clear bit that reads back as one or pulses for the wrong length.

// File: rtl/tsreg_pkg.sv
package tsreg_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int HYST_LO = 9;

  localparam logic [ADDR_W-1:0] A_CAP  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HIGH = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOW  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CRIT = 3'd4;
  localparam logic [ADDR_W-1:0] A_TEMP = 3'd5;
  localparam logic [ADDR_W-1:0] A_MFG  = 3'd6;
  localparam logic [ADDR_W-1:0] A_DEV  = 3'd7;

  typedef struct packed {
    logic cfgWr;        // configuration write this cycle
    logic fieldsOpen;   // mode/pol/enable/hyst may load
    logic critOnlyOpen; // critical-only may be set
    logic shdnSetOpen;  // shutdown may be set
    logic ldHigh;
    logic ldLow;
    logic ldCrit;
  } strobe_t;
endpackage

// File: rtl/tsreg_ctrl.sv
module tsreg_ctrl
  import tsreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              clrBit,
  input  logic              alarmLocked,
  input  logic              critLocked,
  output strobe_t           stb,
  output logic              clearPulse
);
  logic anyLock;
  assign anyLock = alarmLocked | critLocked;

  always_comb begin
    stb              = '0;
    stb.cfgWr        = wrEn && (regAddr == A_CFG);
    stb.fieldsOpen   = !anyLock;
    stb.critOnlyOpen = !alarmLocked;
    stb.shdnSetOpen  = !anyLock;
    stb.ldHigh       = wrEn && (regAddr == A_HIGH) && !alarmLocked;
    stb.ldLow        = wrEn && (regAddr == A_LOW)  && !alarmLocked;
    stb.ldCrit       = wrEn && (regAddr == A_CRIT) && !critLocked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) clearPulse <= 1'b0;
    else       clearPulse <= stb.cfgWr && clrBit;
  end

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cfgWr, stb.ldHigh, stb.ldLow, stb.ldCrit}));
endmodule

// File: rtl/tsreg_datapath.sv
module tsreg_datapath
  import tsreg_pkg::*;
#(
  parameter logic [DATA_W-1:0] CAP_VAL = 16'h007F,
  parameter logic [DATA_W-1:0] MFG_VAL = 16'h1B09,
  parameter logic [DATA_W-1:0] DEV_VAL = 16'h0813
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] tempIn,
  input  logic              eventStatus,
  output logic [DATA_W-1:0] rdData,
  output logic              cfgIntMode,
  output logic              cfgPolHigh,
  output logic              cfgCritOnly,
  output logic              cfgOutEnable,
  output logic              cfgShutdown,
  output logic [1:0]        cfgHyst,
  output logic              alarmLocked,
  output logic              critLocked,
  output logic [DATA_W-1:0] highLimit,
  output logic [DATA_W-1:0] lowLimit,
  output logic [DATA_W-1:0] critLimit
);
  localparam logic [DATA_W-1:0] LIM_MASK = 16'h1FFC;

  logic [DATA_W-1:0] cfgWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgIntMode   <= 1'b0;
      cfgPolHigh   <= 1'b0;
      cfgCritOnly  <= 1'b0;
      cfgOutEnable <= 1'b0;
      cfgShutdown  <= 1'b0;
      cfgHyst      <= 2'b00;
      alarmLocked  <= 1'b0;
      critLocked   <= 1'b0;
    end else if (stb.cfgWr) begin
      if (stb.fieldsOpen) begin
        cfgIntMode   <= wrData[0];
        cfgPolHigh   <= wrData[1];
        cfgOutEnable <= wrData[3];
        cfgHyst      <= wrData[HYST_LO+1:HYST_LO];
      end
      cfgCritOnly <= stb.critOnlyOpen ? wrData[2] : (cfgCritOnly & wrData[2]);
      cfgShutdown <= stb.shdnSetOpen  ? wrData[8] : (cfgShutdown & wrData[8]);
      alarmLocked <= alarmLocked | wrData[6];
      critLocked  <= critLocked  | wrData[7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highLimit <= '0;
      lowLimit  <= '0;
      critLimit <= '0;
    end else begin
      if (stb.ldHigh) highLimit <= wrData & LIM_MASK;
      if (stb.ldLow)  lowLimit  <= wrData & LIM_MASK;
      if (stb.ldCrit) critLimit <= wrData & LIM_MASK;
    end
  end

  assign cfgWord = {5'b0, cfgHyst, cfgShutdown, critLocked, alarmLocked, 1'b0,
                    eventStatus, cfgOutEnable, cfgCritOnly, cfgPolHigh, cfgIntMode};

  always_comb begin
    case (regAddr)
      A_CAP:   rdData = CAP_VAL;
      A_CFG:   rdData = cfgWord;
      A_HIGH:  rdData = highLimit;
      A_LOW:   rdData = lowLimit;
      A_CRIT:  rdData = critLimit;
      A_TEMP:  rdData = tempIn;
      A_MFG:   rdData = MFG_VAL;
      default: rdData = DEV_VAL;
    endcase
  end

  assert_alarm_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    alarmLocked |=> alarmLocked);
  assert_crit_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    critLocked |=> critLocked);
  assert_fields_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (alarmLocked || critLocked) |=> $stable({cfgIntMode, cfgPolHigh, cfgOutEnable, cfgHyst}));
  assert_no_shdn_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((alarmLocked || critLocked) && !cfgShutdown) |=> !cfgShutdown);
  assert_no_critonly_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (alarmLocked && !cfgCritOnly) |=> !cfgCritOnly);
  assert_alarm_limits_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    alarmLocked |=> ($stable(highLimit) && $stable(lowLimit)));
  assert_crit_limit_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    critLocked |=> $stable(critLimit));
endmodule

// File: rtl/tsreg_top.sv
module tsreg_top
  import tsreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] tempIn,
  input  logic              eventStatus,
  output logic              cfgIntMode,
  output logic              cfgPolHigh,
  output logic              cfgCritOnly,
  output logic              cfgOutEnable,
  output logic              cfgShutdown,
  output logic [1:0]        cfgHyst,
  output logic              alarmLocked,
  output logic              critLocked,
  output logic [DATA_W-1:0] highLimit,
  output logic [DATA_W-1:0] lowLimit,
  output logic [DATA_W-1:0] critLimit,
  output logic              clearPulse
);
  strobe_t stb;

  tsreg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .clrBit(wrData[5]),
    .alarmLocked(alarmLocked), .critLocked(critLocked),
    .stb(stb), .clearPulse(clearPulse)
  );

  tsreg_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr), .wrData(wrData),
    .tempIn(tempIn), .eventStatus(eventStatus), .rdData(rdData),
    .cfgIntMode(cfgIntMode), .cfgPolHigh(cfgPolHigh), .cfgCritOnly(cfgCritOnly),
    .cfgOutEnable(cfgOutEnable), .cfgShutdown(cfgShutdown), .cfgHyst(cfgHyst),
    .alarmLocked(alarmLocked), .critLocked(critLocked),
    .highLimit(highLimit), .lowLimit(lowLimit), .critLimit(critLimit)
  );

  assert_clear_needs_cfg_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regAddr == A_CFG && wrData[5]) |=> !clearPulse);
endmodule

// File: tb/sim_tsreg_top.sv
module sim_tsreg_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [15:0] tempIn = 16'h0190;
  logic eventStatus = 1'b0;
  logic cfgIntMode, cfgPolHigh, cfgCritOnly, cfgOutEnable, cfgShutdown;
  logic [1:0] cfgHyst;
  logic alarmLocked, critLocked, clearPulse;
  logic [15:0] highLimit, lowLimit, critLimit;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // bench model
  logic eMode, ePol, eCo, eEn, eShd, eAl, eCl;
  logic [1:0] eHyst;
  logic [15:0] eHigh, eLow, eCrit;

  always #10 clk = ~clk;

  tsreg_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .tempIn(tempIn), .eventStatus(eventStatus),
    .cfgIntMode(cfgIntMode), .cfgPolHigh(cfgPolHigh), .cfgCritOnly(cfgCritOnly),
    .cfgOutEnable(cfgOutEnable), .cfgShutdown(cfgShutdown), .cfgHyst(cfgHyst),
    .alarmLocked(alarmLocked), .critLocked(critLocked),
    .highLimit(highLimit), .lowLimit(lowLimit), .critLimit(critLimit),
    .clearPulse(clearPulse)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; wrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    eMode = 0; ePol = 0; eCo = 0; eEn = 0; eShd = 0; eAl = 0; eCl = 0;
    eHyst = 0; eHigh = 0; eLow = 0; eCrit = 0;
  endtask

  task automatic mdl(logic [2:0] a, logic [15:0] d);
    logic anyL;
    anyL = eAl | eCl;
    case (a)
      3'd1: begin
        if (!anyL) begin eMode = d[0]; ePol = d[1]; eEn = d[3]; eHyst = d[10:9]; end
        eCo  = eAl ? (eCo & d[2]) : d[2];
        eShd = anyL ? (eShd & d[8]) : d[8];
        eAl  = eAl | d[6];
        eCl  = eCl | d[7];
      end
      3'd2: if (!eAl) eHigh = d & 16'h1FFC;
      3'd3: if (!eAl) eLow  = d & 16'h1FFC;
      3'd4: if (!eCl) eCrit = d & 16'h1FFC;
      default: ;
    endcase
  endtask

  // drives at a negedge; returns at the next negedge with the write taken
  task automatic doWrite(logic [2:0] a, logic [15:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    mdl(a, d);
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    regAddr = a; #2; v = rdData;
  endtask

  function automatic logic [15:0] expCfg();
    return {5'b0, eHyst, eShd, eCl, eAl, 1'b0, eventStatus, eEn, eCo, ePol, eMode};
  endfunction

  task automatic checkAll(string req);
    logic [15:0] v;
    rd(3'd1, v); chk(req, v, expCfg());
    rd(3'd2, v); chk(req, v, eHigh);
    rd(3'd3, v); chk(req, v, eLow);
    rd(3'd4, v); chk(req, v, eCrit);
    chk({req, " R12 outputs"},
        {7'b0, cfgHyst, cfgShutdown, critLocked, alarmLocked, cfgOutEnable, cfgCritOnly, cfgPolHigh, cfgIntMode},
        {7'b0, eHyst, eShd, eCl, eAl, eEn, eCo, ePol, eMode});
    chk({req, " R12 limits"}, highLimit ^ lowLimit ^ critLimit, eHigh ^ eLow ^ eCrit);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    doReset();
    // R1 reset values
    rd(3'd0, v); chk("R1 cap", v, 16'h007F);
    rd(3'd6, v); chk("R1 mfg", v, 16'h1B09);
    rd(3'd7, v); chk("R1 dev", v, 16'h0813);
    rd(3'd5, v); chk("R1 temp", v, 16'h0190);
    tempIn = 16'h1C90; rd(3'd5, v); chk("R1 temp follow", v, 16'h1C90);
    checkAll("R1 reset");

    // R2 read-only writes ignored
    for (int i = 0; i < 16; i++) begin
      logic [2:0] a;
      a = (i % 4 == 0) ? 3'd0 : 3'(4 + i % 4);
      doWrite(a, 16'(i * 16'h3B5D + 16'hFFFF));
      rd(3'd0, v); chk("R2 cap", v, 16'h007F);
      rd(3'd6, v); chk("R2 mfg", v, 16'h1B09);
      rd(3'd7, v); chk("R2 dev", v, 16'h0813);
      rd(3'd5, v); chk("R2 temp", v, tempIn);
    end
    checkAll("R2 others");

    // R3 limit masking sweep
    for (int i = 0; i < 192; i++) begin
      doWrite(3'(2 + i % 3), 16'(i * 16'hA5C3 ^ (i << 9)));
      checkAll("R3 limit");
    end
    doWrite(3'd2, 16'hFFFF); rd(3'd2, v); chk("R3 all ones", v, 16'h1FFC);

    // R4/R12 unlocked configuration sweep (locks masked off)
    for (int i = 0; i < 256; i++) begin
      eventStatus = i[0];
      doWrite(3'd1, 16'(i * 16'h9E37 ^ (i << 5)) & 16'hFF3F);
      checkAll("R4 cfg");
    end

    // R5 clear pulse
    doWrite(3'd1, 16'h0020);
    chk("R5 pulse high", 16'(clearPulse), 16'd1);
    rd(3'd1, v); chk("R5 reads 0", v & 16'h0020, 16'h0000);
    @(negedge clk);
    chk("R5 pulse low", 16'(clearPulse), 16'd0);
    doWrite(3'd2, 16'h0020);
    chk("R5 no pulse other reg", 16'(clearPulse), 16'd0);

    // alarm lock phase: R11 same-write fields land
    doReset();
    doWrite(3'd2, 16'h0500); doWrite(3'd3, 16'h0100); doWrite(3'd4, 16'h0700);
    doWrite(3'd1, 16'h054D); // hyst 2, shdn, alarm lock, en, critOnly, mode
    checkAll("R11 same write");
    chk("R11 shutdown", 16'(cfgShutdown), 16'd1);
    doWrite(3'd1, 16'h0000);
    checkAll("R8 R9 clear under lock");
    chk("R8 shdn cleared", 16'(cfgShutdown), 16'd0);
    chk("R9 critOnly cleared", 16'(cfgCritOnly), 16'd0);
    chk("R6 alarm kept", 16'(alarmLocked), 16'd1);
    doWrite(3'd1, 16'h0106);
    chk("R8 shdn not set", 16'(cfgShutdown), 16'd0);
    chk("R9 critOnly not set", 16'(cfgCritOnly), 16'd0);
    chk("R7 pol frozen", 16'(cfgPolHigh), 16'd0);
    doWrite(3'd2, 16'h0A00); doWrite(3'd3, 16'h0A00); doWrite(3'd4, 16'h0A00);
    checkAll("R10 alarm lock");
    rd(3'd2, v); chk("R10 high held", v, 16'h0500);
    rd(3'd4, v); chk("R10 crit written", v, 16'h0A00);
    for (int i = 0; i < 64; i++) begin
      doWrite(3'(1 + i % 4), 16'(i * 16'h7F4B));
      checkAll("R7 locked sweep");
    end

    // critical lock phase
    doReset();
    doWrite(3'd1, 16'h0080);
    doWrite(3'd4, 16'h0300); doWrite(3'd2, 16'h0300);
    rd(3'd4, v); chk("R10 crit held", v, 16'h0000);
    rd(3'd2, v); chk("R10 high free", v, 16'h0300);
    doWrite(3'd1, 16'h0004);
    chk("R9 critOnly free under crit lock", 16'(cfgCritOnly), 16'd1);
    doWrite(3'd1, 16'h0100);
    chk("R8 shdn blocked", 16'(cfgShutdown), 16'd0);
    chk("R6 crit kept", 16'(critLocked), 16'd1);
    for (int i = 0; i < 64; i++) begin
      doWrite(3'(1 + i % 4), 16'(i * 16'h2C91 + 16'h0101));
      checkAll("R6 crit sweep");
    end
    doReset();
    chk("R6 reset clears", {14'b0, alarmLocked, critLocked}, 16'd0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule